// File: doc/BRIEF.md
# Register Pair Alias Map

This block keeps a small indirection table between architectural register-pair names and the physical slots of a seven-entry, 16-bit register file. An exchange instruction does not copy any data. It rewrites a few 3-bit slot pointers, so every exchange finishes in a single clock and the file contents stay where they are.

Seven names are visible at the ports. They are two working pairs, DE and HL, two index pairs, a stack pointer, and the two alternate pairs DE' and HL'. The pointers for the alternates live together in one 6-bit field. The alternate-set exchange trades that field with the DE and HL pointers in one step.

Five exchange commands exist, each on its own request bit. Using only the alternate-set, DE/HL and SP/HL exchanges, any arrangement of the five values in DE, HL, DE', HL' and SP can be reached. The file itself is included, so the remapping can be observed end to end through one combinational read port and one clocked write port.

Top module: `regpair_alias_map`

## Requirements
- R1: While reset is asserted, and after it is released, the pointers are as follows: DE to slot 0, HL to slot 1, index pair 0 to slot 2, index pair 1 to slot 3, SP to slot 4, DE' to slot 5 and HL' to slot 6. All file entries read as zero.
- R2: Name codes are DE=0, HL=1, X0=2, X1=3, SP=4, DE'=5, HL'=6, and 7 means no register. `rd_slot_o` and `wr_slot_o` show, in the same cycle, the slot that the current mapping gives to `rd_name_i` and `wr_name_i`. `rd_data_o` shows that slot's contents in the same cycle. A write stores `wr_data_i` into the slot of `wr_name_i` at the clock edge.
- R3: `xchg_i[0]` swaps the DE and HL pointers with the DE' and HL' pointers. DE takes the old DE' slot and HL takes the old HL' slot, and the reverse also happens. This takes effect at the next edge.
- R4: `xchg_i[1]` swaps the DE and HL pointers at the next edge.
- R5: `xchg_i[2]` swaps the SP and HL pointers at the next edge.
- R6: `xchg_i[3]` swaps DE with index pair 0, and `xchg_i[4]` swaps DE with index pair 1, each at the next edge.
- R7: If several request bits are set in one cycle, only the lowest-numbered set bit is applied. The others are ignored.
- R8: A read or write in the same cycle as an exchange uses the mapping from before that exchange.
- R9: Name 7 reads slot 7 with data zero. A write to name 7 changes no register.
- R10: An exchange never changes the contents of any physical slot. With no request bit set, the mapping holds.
- R11: The seven pointers always form a permutation of slots 0 to 6. The DE/HL, SP/HL and alternate-set exchanges together reach all 120 arrangements of DE, HL, DE', HL' and SP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xchg_i | input | 5 | Exchange requests: bit 0 alternate set, bit 1 DE/HL, bit 2 SP/HL, bit 3 DE/X0, bit 4 DE/X1 |
| rd_name_i | input | 3 | Architectural name to read |
| wr_name_i | input | 3 | Architectural name to write |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | 16 | Write data |
| rd_slot_o | output | 3 | Physical slot selected for the read |
| wr_slot_o | output | 3 | Physical slot selected for the write |
| rd_data_o | output | 16 | Contents of the read slot |

## Verification
If a pointer is wrong, `rd_slot_o` or `wr_slot_o` shows the wrong slot in the same cycle that the affected name is presented. A slot that two names share, or that holds corrupted data, shows up as a wrong `rd_data_o` value the next time either name is read. The bench presents a name on every cycle and regularly sweeps all eight codes, so a fault is reported within a few cycles of being exposed. The reachability phase reads the slots of the five exchangeable names back from the ports after each exchange. If a dropped or mis-ordered exchange leaves any of the 120 arrangements unreachable, the final count of distinct arrangements comes out below 120.

// File: rtl/rpam_pkg.sv
`timescale 1ns/1ps
package rpam_pkg;

    localparam int SLOT_W    = 3;
    localparam int NUM_SLOTS = 7;
    localparam int NUM_XCHG  = 5;

    // exchange request bit positions, lowest index has highest priority
    localparam int XC_ALT   = 0;
    localparam int XC_DE_HL = 1;
    localparam int XC_SP_HL = 2;
    localparam int XC_DE_X0 = 3;
    localparam int XC_DE_X1 = 4;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [SLOT_W-1:0] {
        NM_DE     = 3'd0,
        NM_HL     = 3'd1,
        NM_X0     = 3'd2,
        NM_X1     = 3'd3,
        NM_SP     = 3'd4,
        NM_DE_ALT = 3'd5,
        NM_HL_ALT = 3'd6,
        NM_NONE   = 3'd7
    } name_e;

    typedef struct packed {
        slot_t                 de;
        slot_t                 hl;
        slot_t                 x0;
        slot_t                 x1;
        slot_t                 sp;
        logic [2*SLOT_W-1:0]   alt;   // upper half: DE', lower half: HL'
    } ptr_set_t;

    localparam ptr_set_t PTR_RESET = '{
        de:  3'd0,
        hl:  3'd1,
        x0:  3'd2,
        x1:  3'd3,
        sp:  3'd4,
        alt: 6'b101_110
    };

    localparam slot_t SLOT_NONE = 3'd7;

endpackage

// File: rtl/rpam_prio_pick.sv
`timescale 1ns/1ps
module rpam_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pick
            if (g == 0) begin : g_first
                assign grant_o[g] = req_i[g];
            end else begin : g_rest
                assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/rpam_ptr_table.sv
`timescale 1ns/1ps
module rpam_ptr_table
    import rpam_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_XCHG-1:0] xchg_i,
    output ptr_set_t            ptr_o
);

    logic [NUM_XCHG-1:0] grant;
    ptr_set_t            ptr_d;
    ptr_set_t            ptr_q;

    rpam_prio_pick #(.N(NUM_XCHG)) i_pick (
        .req_i   (xchg_i),
        .grant_o (grant)
    );

    always_comb begin
        ptr_d = ptr_q;
        if (grant[XC_ALT]) begin
            ptr_d.de  = ptr_q.alt[2*SLOT_W-1:SLOT_W];
            ptr_d.hl  = ptr_q.alt[SLOT_W-1:0];
            ptr_d.alt = {ptr_q.de, ptr_q.hl};
        end
        if (grant[XC_DE_HL]) begin
            ptr_d.de = ptr_q.hl;
            ptr_d.hl = ptr_q.de;
        end
        if (grant[XC_SP_HL]) begin
            ptr_d.sp = ptr_q.hl;
            ptr_d.hl = ptr_q.sp;
        end
        if (grant[XC_DE_X0]) begin
            ptr_d.de = ptr_q.x0;
            ptr_d.x0 = ptr_q.de;
        end
        if (grant[XC_DE_X1]) begin
            ptr_d.de = ptr_q.x1;
            ptr_d.x1 = ptr_q.de;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= PTR_RESET;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/rpam_name_map.sv
`timescale 1ns/1ps
module rpam_name_map
    import rpam_pkg::*;
(
    input  ptr_set_t    ptr_i,
    input  logic [2:0]  name_i,
    output slot_t       slot_o
);

    name_e name;

    always_comb begin
        name = name_e'(name_i);
        unique case (name)
            NM_DE:     slot_o = ptr_i.de;
            NM_HL:     slot_o = ptr_i.hl;
            NM_X0:     slot_o = ptr_i.x0;
            NM_X1:     slot_o = ptr_i.x1;
            NM_SP:     slot_o = ptr_i.sp;
            NM_DE_ALT: slot_o = ptr_i.alt[2*SLOT_W-1:SLOT_W];
            NM_HL_ALT: slot_o = ptr_i.alt[SLOT_W-1:0];
            default:   slot_o = SLOT_NONE;
        endcase
    end

endmodule

// File: rtl/rpam_regfile.sv
`timescale 1ns/1ps
module rpam_regfile
    import rpam_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  slot_t                             wr_slot_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    input  slot_t                             rd_slot_i,
    output logic [DATA_W-1:0]                 rd_data_o,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  file_o
);

    logic [NUM_SLOTS-1:0]              wr_hit;
    logic [NUM_SLOTS-1:0]              rd_hit;
    logic [NUM_SLOTS-1:0][DATA_W-1:0]  file_d;
    logic [NUM_SLOTS-1:0][DATA_W-1:0]  file_q;

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
            assign wr_hit[g] = wr_en_i && (wr_slot_i == slot_t'(g));
            assign rd_hit[g] = (rd_slot_i == slot_t'(g));
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            file_d[i] = wr_hit[i] ? wr_data_i : file_q[i];
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_hit[i]) begin
                rd_data_o = file_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            file_q <= '0;
        end else begin
            file_q <= file_d;
        end
    end

    assign file_o = file_q;

endmodule

// File: rtl/regpair_alias_map.sv
`timescale 1ns/1ps
module regpair_alias_map
    import rpam_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        xchg_i,
    input  logic [2:0]        rd_name_i,
    input  logic [2:0]        wr_name_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [2:0]        rd_slot_o,
    output logic [2:0]        wr_slot_o,
    output logic [DATA_W-1:0] rd_data_o
);

    ptr_set_t                          ptr_q;
    slot_t                             rd_slot;
    slot_t                             wr_slot;
    logic [NUM_SLOTS-1:0][DATA_W-1:0]  file_q;

    rpam_ptr_table i_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .xchg_i (xchg_i),
        .ptr_o  (ptr_q)
    );

    rpam_name_map i_rd_map (
        .ptr_i  (ptr_q),
        .name_i (rd_name_i),
        .slot_o (rd_slot)
    );

    rpam_name_map i_wr_map (
        .ptr_i  (ptr_q),
        .name_i (wr_name_i),
        .slot_o (wr_slot)
    );

    rpam_regfile #(.DATA_W(DATA_W)) i_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_slot_i (wr_slot),
        .wr_data_i (wr_data_i),
        .rd_slot_i (rd_slot),
        .rd_data_o (rd_data_o),
        .file_o    (file_q)
    );

    assign rd_slot_o = rd_slot;
    assign wr_slot_o = wr_slot;

endmodule

// File: rtl/rpam_checker.sv
`timescale 1ns/1ps
module rpam_checker
    import rpam_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [4:0]                        xchg_i,
    input  logic [2:0]                        rd_name_i,
    input  logic [DATA_W-1:0]                 rd_data_o,
    input  logic [2:0]                        wr_name_i,
    input  logic                              wr_en_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    input  logic [2:0]                        wr_slot_o,
    input  ptr_set_t                          ptr_q,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  file_q
);

    logic [7:0] occ;

    always_comb begin
        occ = '0;
        occ[ptr_q.de] = 1'b1;
        occ[ptr_q.hl] = 1'b1;
        occ[ptr_q.x0] = 1'b1;
        occ[ptr_q.x1] = 1'b1;
        occ[ptr_q.sp] = 1'b1;
        occ[ptr_q.alt[5:3]] = 1'b1;
        occ[ptr_q.alt[2:0]] = 1'b1;
    end

    p_reset_map_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (ptr_q == PTR_RESET));

    p_exx_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_i[0] |=> (ptr_q.de == $past(ptr_q.alt[5:3])) && (ptr_q.hl == $past(ptr_q.alt[2:0]))
                      && (ptr_q.alt == {$past(ptr_q.de), $past(ptr_q.hl)}));

    p_de_hl_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_i == 5'b00010) |=> (ptr_q.de == $past(ptr_q.hl)) && (ptr_q.hl == $past(ptr_q.de)));

    p_sp_hl_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_i == 5'b00100) |=> (ptr_q.sp == $past(ptr_q.hl)) && (ptr_q.hl == $past(ptr_q.sp)));

    p_low_bit_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_i[1] && xchg_i[2] && !xchg_i[0]) |=> (ptr_q.sp == $past(ptr_q.sp)));

    p_write_old_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_name_i != 3'd7)) |=> (file_q[$past(wr_slot_o)] == $past(wr_data_i)));

    p_none_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_name_i == 3'd7) |-> (rd_data_o == '0));

    p_no_data_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(file_q));

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_i == 5'b00000) |=> $stable(ptr_q));

    p_permutation_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == 8'h7F));

endmodule

bind regpair_alias_map rpam_checker #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xchg_i    (xchg_i),
    .rd_name_i (rd_name_i),
    .rd_data_o (rd_data_o),
    .wr_name_i (wr_name_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wr_slot_o (wr_slot_o),
    .ptr_q     (ptr_q),
    .file_q    (file_q)
);

// File: tb/test_regpair_alias_map.sv
`timescale 1ns/1ps
module test_regpair_alias_map;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  xchg = '0;
    logic [2:0]  rd_name = '0;
    logic [2:0]  wr_name = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_slot_o;
    logic [2:0]  wr_slot_o;
    logic [15:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference: value and slot seen under each name code (7 = none)
    int m_val[8];
    int m_slot[8];
    int obs_rs;
    int obs_ws;

    regpair_alias_map i_regpair_alias_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .xchg_i    (xchg),
        .rd_name_i (rd_name),
        .wr_name_i (wr_name),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_slot_o (rd_slot_o),
        .wr_slot_o (wr_slot_o),
        .rd_data_o (rd_data_o)
    );

    always #2.5 clk = ~clk;

    function automatic void swap_names(int a, int b, ref int arr[8]);
        int t;
        t = arr[a];
        arr[a] = arr[b];
        arr[b] = t;
    endfunction

    // only the lowest set request bit counts (R7)
    function automatic void permute(logic [4:0] x, ref int arr[8]);
        if (x[0]) begin
            swap_names(0, 5, arr);
            swap_names(1, 6, arr);
        end else if (x[1]) swap_names(0, 1, arr);
        else if (x[2]) swap_names(4, 1, arr);
        else if (x[3]) swap_names(0, 2, arr);
        else if (x[4]) swap_names(0, 3, arr);
    endfunction

    function automatic int key_of(ref int s[8]);
        return s[0] | (s[1] << 3) | (s[5] << 6) | (s[6] << 9) | (s[4] << 12);
    endfunction

    function automatic int pred_key(logic [4:0] x);
        int s[8];
        s = m_slot;
        permute(x, s);
        return key_of(s);
    endfunction

    task automatic model_reset();
        for (int n = 0; n < 8; n++) begin
            m_val[n] = 0;
            m_slot[n] = n;
        end
    endtask

    task automatic step(input logic [4:0] x, input logic [2:0] rn, input logic [2:0] wn,
                        input logic we, input logic [15:0] d, input string tag);
        logic [2:0]  e_rs;
        logic [2:0]  e_ws;
        logic [15:0] e_rd;
        @(negedge clk);
        xchg = x; rd_name = rn; wr_name = wn; wr_en = we; wr_data = d;
        #1;
        e_rs = 3'(m_slot[rn]);
        e_ws = 3'(m_slot[wn]);
        e_rd = (rn == 3'd7) ? 16'h0 : 16'(m_val[rn]);
        checks++;
        if (rd_slot_o !== e_rs || wr_slot_o !== e_ws || rd_data_o !== e_rd) begin
            failures++;
            $display("FAIL %s: name rd=%0d wr=%0d rd_slot %0d exp %0d, wr_slot %0d exp %0d, rd_data %h exp %h",
                     tag, rn, wn, rd_slot_o, e_rs, wr_slot_o, e_ws, rd_data_o, e_rd);
        end
        obs_rs = int'(rd_slot_o);
        obs_ws = int'(wr_slot_o);
        @(posedge clk);
        if (we && wn != 3'd7) m_val[wn] = int'(d);
        permute(x, m_val);
        permute(x, m_slot);
    endtask

    task automatic sweep(input string tag);
        for (int n = 0; n < 8; n++) step(5'b0, 3'(n), 3'(7 - n), 1'b0, 16'h0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; xchg = '0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        bit seen[int];
        int found;
        int k;
        logic [4:0] cmd;
        logic [4:0] opts[3];
        model_reset();
        do_reset();
        sweep("R1 R2 R9 reset map");

        for (int n = 0; n < 7; n++) step(5'b0, 3'd7, 3'(n), 1'b1, 16'(16'hA000 + n * 16'h0111), "R2 write");
        sweep("R2 readback");

        step(5'b00001, 3'd0, 3'd0, 1'b0, 16'h0, "R3");  sweep("R3 R10 alternate swap");
        step(5'b00010, 3'd1, 3'd1, 1'b0, 16'h0, "R4");  sweep("R4 R10 de/hl swap");
        step(5'b00100, 3'd4, 3'd4, 1'b0, 16'h0, "R5");  sweep("R5 R10 sp/hl swap");
        step(5'b01000, 3'd2, 3'd2, 1'b0, 16'h0, "R6");  sweep("R6 R10 de/x0 swap");
        step(5'b10000, 3'd3, 3'd3, 1'b0, 16'h0, "R6");  sweep("R6 R10 de/x1 swap");

        step(5'b00110, 3'd1, 3'd4, 1'b0, 16'h0, "R7");  sweep("R7 pair 1+2");
        step(5'b11000, 3'd0, 3'd2, 1'b0, 16'h0, "R7");  sweep("R7 pair 3+4");
        step(5'b11111, 3'd0, 3'd5, 1'b0, 16'h0, "R7");  sweep("R7 all bits");

        step(5'b00010, 3'd0, 3'd0, 1'b1, 16'hBEEF, "R8 same-cycle read");
        sweep("R8 write under old map");
        step(5'b00001, 3'd1, 3'd5, 1'b1, 16'h1234, "R8 same-cycle read");
        sweep("R8 write under old map");

        step(5'b0, 3'd7, 3'd7, 1'b1, 16'hDEAD, "R9 none write");
        sweep("R9 none write ignored");

        do_reset();
        sweep("R1 second reset");

        // reachability of all 120 arrangements, slots read back at the ports
        opts[0] = 5'b00001; opts[1] = 5'b00010; opts[2] = 5'b00100;
        found = 0;
        for (int r = 0; r < 1500 && found < 120; r++) begin
            step(5'b0, 3'd0, 3'd1, 1'b0, 16'h0, "R11 key");
            k = obs_rs | (obs_ws << 3);
            step(5'b0, 3'd5, 3'd6, 1'b0, 16'h0, "R11 key");
            k = k | (obs_rs << 6) | (obs_ws << 9);
            step(5'b0, 3'd4, 3'd4, 1'b0, 16'h0, "R11 key");
            k = k | (obs_rs << 12);
            if (!seen.exists(k)) begin
                seen[k] = 1'b1;
                found++;
            end
            cmd = opts[$urandom % 3];
            for (int c = 2; c >= 0; c--) if (!seen.exists(pred_key(opts[c]))) cmd = opts[c];
            step(cmd, 3'd0, 3'd0, 1'b0, 16'h0, "R11 walk");
        end
        checks++;
        if (found != 120) begin
            failures++;
            $display("FAIL R11: distinct arrangements %0d exp 120", found);
        end

        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [4:0] x;
            r = $urandom % 8;
            if (r < 3) x = 5'b0;
            else if (r < 7) x = 5'(1 << ($urandom % 5));
            else x = 5'($urandom % 32);
            step(x, 3'($urandom % 8), 3'($urandom % 8), 1'($urandom % 2), 16'($urandom),
                 "R2 R7 R8 R10 R11 random");
        end
        sweep("R10 R11 final");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule